// File: doc/BRIEF.md
# Compare-Terminated Byte String Loader

This unit moves a string of bytes from memory into a bank of 32-bit registers. Once started, it reads one byte per memory transaction from consecutive addresses. It places the bytes big-endian into successive registers: the most significant lane of a register is filled first, and the register number advances after the least significant lane. Every register write is a single-lane write, so lanes the string does not reach keep their old contents.

The transfer ends early when a loaded byte equals a programmed compare byte. That byte is still written. The unit then reports the position of the byte that ended the transfer, or the full byte count if no byte matched. Two register numbers, the base and the index used to form the address, are protected: writes aimed at them are dropped, but the lane and register sequence advances as if the write had happened. A mode input limits the address to 32 bits, with wrap-around.

Top module: `lsc_unit`

## Requirements
- R1: After `start` is accepted while idle with a nonzero count, byte reads are issued one at a time. `rd_req` is high for exactly one cycle per read. The first read uses `start_addr`, and each later read uses the previous address plus one.
- R2: Byte k of the transfer (counting from 0) goes to lane k mod 4 of its register. Lane 0 is bits 31:24, written with `wr_mask` = 4'b1000. Lane 3 is bits 7:0, written with `wr_mask` = 4'b0001.
- R3: The first register is `first_reg`. After lane 3 is written, the next byte goes to the following register number, and register 31 is followed by register 0.
- R4: Every write sets exactly one bit of `wr_mask` and carries the loaded byte in all four lanes of `wr_data`. Lanes outside the mask stay unchanged.
- R5: No write is issued to `index_reg`. The byte meant for it is dropped, and the following bytes keep their normal positions.
- R6: When `base_reg` is nonzero, no write is issued to `base_reg`, and later bytes keep their positions. When `base_reg` is 0, register 0 is written normally.
- R7: When a loaded byte equals `cmp_byte`, that byte is still written and no further read is issued. `count_out` then equals that byte's position (0 for the first byte).
- R8: If no byte matches, exactly `byte_count` reads take place and `count_out` equals `byte_count`.
- R9: A `byte_count` of 0 produces `done` in the cycle after `start`, with `count_out` = 0, and no read or write.
- R10: With `addr32` high, bits 63:32 of `rd_addr` are zero and the address wraps from 32'hFFFFFFFF to 0. With `addr32` low, the increment carries into bit 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| start_addr | input | 64 | Address of the first byte |
| byte_count | input | 7 | Number of bytes to load |
| cmp_byte | input | 8 | Byte value that ends the transfer |
| first_reg | input | 5 | Register that receives the first byte |
| base_reg | input | 5 | Protected base register (0 means none) |
| index_reg | input | 5 | Protected index register |
| addr32 | input | 1 | 32-bit address mode |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 64 | Byte read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Read data byte |
| wr_en | output | 1 | Register lane write enable |
| wr_reg | output | 5 | Register number written |
| wr_mask | output | 4 | One-hot lane enable, bit 3 = bits 31:24 |
| wr_data | output | 32 | Loaded byte replicated in every lane |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| count_out | output | 7 | Returned byte count |

## Verification
The bench checks five kinds of transfer, and each separates a different failure:

- **No match, ending mid-register:** catches wrong lane order and off-by-one counts.
- **Starting at register 30:** shows whether the register number wraps past 31.
- **Matches at the first and at a middle byte:** show whether the matching byte is still written, whether reading stops, and whether the returned count is the position or the position plus one.
- **Protected index and base registers:** inside and outside the sequence, with the base at 0, they check suppression and continued sequencing separately.
- **Address near 2^32-1 in both address modes:** shows whether the carry into bit 32 is kept or dropped.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = BYTE_W * LANES;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } lsc_state_e;
endpackage

// File: rtl/lsc_ctrl.sv
module lsc_ctrl #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] byte_count,
  input  logic          rd_valid,
  input  logic          match,
  output logic          load,
  output logic          fire,
  output logic          rd_req,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] count_out
);
  import lsc_pkg::*;

  lsc_state_e    state_q, state_d;
  logic [CW-1:0] pos_q, pos_d;
  logic [CW-1:0] total_q, total_d;
  logic [CW-1:0] res_q, res_d;
  logic          res_en;

  assign load   = (state_q == ST_IDLE) && start;
  assign fire   = (state_q == ST_WAIT) && rd_valid;
  assign rd_req = (state_q == ST_REQ);
  assign busy   = (state_q != ST_IDLE);
  assign done   = (state_q == ST_DONE);
  assign count_out = res_q;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    total_d = total_q;
    res_d   = res_q;
    res_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          total_d = byte_count;
          pos_d   = '0;
          if (byte_count == '0) begin
            res_d   = '0;
            res_en  = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_REQ;
          end
        end
      end
      ST_REQ: state_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_valid) begin
          if (match) begin
            res_d   = pos_q;
            res_en  = 1'b1;
            state_d = ST_DONE;
          end else if (pos_q == CW'(total_q - 1'b1)) begin
            res_d   = total_q;
            res_en  = 1'b1;
            state_d = ST_DONE;
          end else begin
            pos_d   = CW'(pos_q + 1'b1);
            state_d = ST_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      total_q <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      total_q <= total_d;
      if (res_en) res_q <= res_d;
    end
  end
endmodule

// File: rtl/lsc_addr_gen.sv
module lsc_addr_gen #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] start_addr,
  input  logic          addr32,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q, addr_d, inc, raw;
  logic          m32_q;

  assign inc = AW'(addr_q + 1'b1);
  assign raw = load ? start_addr : inc;
  wire   m32 = load ? addr32 : m32_q;

  generate
    if (AW > 32) begin : g_wide
      assign addr_d = m32 ? {{(AW-32){1'b0}}, raw[31:0]} : raw;
    end else begin : g_narrow
      logic unused_m32;
      assign unused_m32 = m32;
      assign addr_d = raw;
    end
  endgenerate

  assign addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      m32_q  <= 1'b0;
    end else begin
      if (load || step) addr_q <= addr_d;
      if (load) m32_q <= addr32;
    end
  end
endmodule

// File: rtl/lsc_lane_seq.sv
module lsc_lane_seq #(
  parameter int REGS  = 32,
  parameter int LANES = 4,
  localparam int RW   = $clog2(REGS),
  localparam int LW   = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             fire,
  input  logic [RW-1:0]    first_reg,
  input  logic [RW-1:0]    base_reg,
  input  logic [RW-1:0]    index_reg,
  output logic             wr_en,
  output logic [RW-1:0]    wr_reg,
  output logic [LANES-1:0] wr_mask
);
  logic [RW-1:0] reg_q, reg_d, base_q, idx_q;
  logic [LW-1:0] lane_q, lane_d;
  logic          blocked;

  always_comb begin
    reg_d  = reg_q;
    lane_d = lane_q;
    if (load) begin
      reg_d  = first_reg;
      lane_d = '0;
    end else if (fire) begin
      if (lane_q == LW'(LANES-1)) begin
        lane_d = '0;
        reg_d  = (reg_q == RW'(REGS-1)) ? '0 : RW'(reg_q + 1'b1);
      end else begin
        lane_d = LW'(lane_q + 1'b1);
      end
    end
  end

  assign blocked = (reg_q == idx_q) || ((base_q != '0) && (reg_q == base_q));
  assign wr_en   = fire && !blocked;
  assign wr_reg  = reg_q;
  assign wr_mask = LANES'(1) << (LANES - 1 - int'(lane_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      lane_q <= '0;
      base_q <= '0;
      idx_q  <= '0;
    end else begin
      if (load || fire) begin
        reg_q  <= reg_d;
        lane_q <= lane_d;
      end
      if (load) begin
        base_q <= base_reg;
        idx_q  <= index_reg;
      end
    end
  end
endmodule

// File: rtl/lsc_unit.sv
module lsc_unit #(
  parameter int AW   = 64,
  parameter int CW   = 7,
  parameter int REGS = 32,
  localparam int RW  = $clog2(REGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [AW-1:0]             start_addr,
  input  logic [CW-1:0]             byte_count,
  input  logic [lsc_pkg::BYTE_W-1:0] cmp_byte,
  input  logic [RW-1:0]             first_reg,
  input  logic [RW-1:0]             base_reg,
  input  logic [RW-1:0]             index_reg,
  input  logic                      addr32,
  output logic                      rd_req,
  output logic [AW-1:0]             rd_addr,
  input  logic                      rd_valid,
  input  logic [lsc_pkg::BYTE_W-1:0] rd_data,
  output logic                      wr_en,
  output logic [RW-1:0]             wr_reg,
  output logic [lsc_pkg::LANES-1:0] wr_mask,
  output logic [lsc_pkg::WORD_W-1:0] wr_data,
  output logic                      busy,
  output logic                      done,
  output logic [CW-1:0]             count_out
);
  import lsc_pkg::*;

  logic              load, fire, match;
  logic [BYTE_W-1:0] cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else if (load) cmp_q <= cmp_byte;
  end

  assign match   = (rd_data == cmp_q);
  assign wr_data = {LANES{rd_data}};

  lsc_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .rd_valid(rd_valid), .match(match), .load(load), .fire(fire),
    .rd_req(rd_req), .busy(busy), .done(done), .count_out(count_out)
  );

  lsc_addr_gen #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(fire),
    .start_addr(start_addr), .addr32(addr32), .addr(rd_addr)
  );

  lsc_lane_seq #(.REGS(REGS), .LANES(LANES)) u_lane (
    .clk(clk), .rst_n(rst_n), .load(load), .fire(fire),
    .first_reg(first_reg), .base_reg(base_reg), .index_reg(index_reg),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_mask(wr_mask)
  );
endmodule

// File: rtl/lsc_unit_chk.sv
module lsc_unit_chk #(
  parameter int AW   = 64,
  parameter int CW   = 7,
  parameter int REGS = 32,
  localparam int RW  = $clog2(REGS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] start_addr,
  input logic [CW-1:0] byte_count,
  input logic [7:0]    cmp_byte,
  input logic [RW-1:0] base_reg,
  input logic [RW-1:0] index_reg,
  input logic          addr32,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic [7:0]    rd_data,
  input logic          wr_en,
  input logic [RW-1:0] wr_reg,
  input logic [3:0]    wr_mask,
  input logic [31:0]   wr_data,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] count_out
);
  logic          acc;
  logic [CW-1:0] cnt_q;
  logic [7:0]    cmp_q;
  logic [RW-1:0] base_q, idx_q;
  logic          m32_q, seen_q, pend_q;
  logic [AW-1:0] next_q, nxt;

  assign acc = start && !busy;
  assign nxt = AW'(rd_addr + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; cmp_q <= '0; base_q <= '0; idx_q <= '0;
      m32_q <= 1'b0; seen_q <= 1'b0; pend_q <= 1'b0; next_q <= '0;
    end else begin
      if (acc) begin
        cnt_q <= byte_count; cmp_q <= cmp_byte; base_q <= base_reg;
        idx_q <= index_reg; m32_q <= addr32; seen_q <= 1'b0;
      end else if (rd_req) begin
        seen_q <= 1'b1;
        next_q <= (m32_q && AW > 32) ? (nxt & AW'(64'hFFFF_FFFF)) : nxt;
      end
      if (rd_req) pend_q <= 1'b1;
      else if (rd_valid) pend_q <= 1'b0;
    end
  end

  a_r1_single_cycle_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && seen_q) |-> (rd_addr == next_q));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !wr_en));
  a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(wr_mask) == 1 && wr_data[31:24] == rd_data && wr_data[7:0] == rd_data));
  a_r5_index_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_reg != idx_q));
  a_r6_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && base_q != '0) |-> (wr_reg != base_q));
  a_r7_match_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && rd_valid && rd_data == cmp_q) |=> done);
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (count_out <= cnt_q));
  a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && byte_count == '0) |=> (done && count_out == '0 && !rd_req));
  a_r10_high_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && m32_q && AW > 32) |-> ((rd_addr >> 32) == '0));
endmodule

bind lsc_unit lsc_unit_chk #(.AW(AW), .CW(CW), .REGS(REGS)) u_chk (.*);

// File: tb/lsc_unit_test.sv
`timescale 1ns/1ps
module lsc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] start_addr = '0;
  logic [6:0]  byte_count = '0;
  logic [7:0]  cmp_byte = '0;
  logic [4:0]  first_reg = '0, base_reg = '0, index_reg = '0;
  logic        addr32 = 1'b0;
  logic        rd_req, rd_valid = 1'b0;
  logic [63:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        wr_en, busy, done;
  logic [4:0]  wr_reg;
  logic [3:0]  wr_mask;
  logic [31:0] wr_data;
  logic [6:0]  count_out;

  int checks = 0, fails = 0;
  logic [31:0] breg [32];
  logic [31:0] ereg [32];
  logic [63:0] alog [128];
  int nreads = 0;
  logic [6:0] got_cnt;

  always #5 clk = ~clk;

  lsc_unit uut (.*);

  function automatic logic [7:0] mem_byte(input logic [63:0] a);
    return 8'(a[7:0] + 8'h10);
  endfunction

  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (rd_req) begin
      rd_valid <= 1'b1;
      rd_data  <= mem_byte(rd_addr);
      if (nreads < 128) alog[nreads] = rd_addr;
      nreads = nreads + 1;
    end
  end

  always @(negedge clk) begin
    if (wr_en)
      for (int l = 0; l < 4; l++)
        if (wr_mask[l]) breg[wr_reg][8*l +: 8] = wr_data[8*l +: 8];
  end

  initial begin
    #1_000_000;
    fails = fails + 1;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic exec(input logic [63:0] a, input int n, input logic [7:0] c,
                      input logic [4:0] fr, input logic [4:0] br,
                      input logic [4:0] ir, input logic m32,
                      output int e_cnt, output int e_rd);
    logic [63:0] ea;
    for (int r = 0; r < 32; r++) begin
      breg[r] = 32'hC0DE_0000 | r;
      ereg[r] = breg[r];
    end
    e_cnt = n; e_rd = n; ea = m32 ? {32'h0, a[31:0]} : a;
    for (int i = 0; i < n; i++) begin
      logic [4:0] t;
      logic [7:0] b;
      b = mem_byte(ea);
      t = 5'(fr + i / 4);
      if (!(t == ir || (br != 0 && t == br))) ereg[t][31 - 8*(i%4) -: 8] = b;
      if (b == c) begin e_cnt = i; e_rd = i + 1; break; end
      ea = m32 ? {32'h0, 32'(ea[31:0] + 1)} : ea + 1;
    end
    @(negedge clk);
    nreads = 0;
    start_addr = a; byte_count = 7'(n); cmp_byte = c; first_reg = fr;
    base_reg = br; index_reg = ir; addr32 = m32; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
    got_cnt = count_out;
  endtask

  task automatic verify(input string tag, input logic [63:0] a, input logic m32,
                        input int e_cnt, input int e_rd);
    logic [63:0] ea;
    chk({tag, " done/count"}, {done, got_cnt}, {1'b1, 7'(e_cnt)});
    chk({tag, " reads"}, 64'(nreads), 64'(e_rd));
    ea = m32 ? {32'h0, a[31:0]} : a;
    for (int i = 0; i < e_rd && i < 128; i++) begin
      if (alog[i] !== ea) chk({tag, " addr"}, alog[i], ea);
      ea = m32 ? {32'h0, 32'(ea[31:0] + 1)} : ea + 1;
    end
    for (int r = 0; r < 32; r++)
      if (breg[r] !== ereg[r]) chk({tag, " reg"}, {r[31:0], breg[r]}, {r[31:0], ereg[r]});
    chk({tag, " regfile"}, 64'(1), 64'(1));
  endtask

  task automatic t_reset();
    chk("R1 reset quiet", {busy, rd_req, wr_en, done}, 4'b0000);
  endtask

  task automatic t_no_match();   // R2 R8: 10 bytes, ends mid-register
    int ec, er;
    exec(64'h1000, 10, 8'h00, 5'd3, 5'd0, 5'd20, 1'b0, ec, er);
    verify("R2 R8 no match", 64'h1000, 1'b0, ec, er);
  endtask

  task automatic t_reg_wrap();   // R3: start at 30
    int ec, er;
    exec(64'h2040, 13, 8'h00, 5'd30, 5'd0, 5'd10, 1'b0, ec, er);
    verify("R3 reg wrap", 64'h2040, 1'b0, ec, er);
  endtask

  task automatic t_lanes();      // R4: two bytes keep lower lanes
    int ec, er;
    exec(64'h3077, 2, 8'h00, 5'd5, 5'd0, 5'd9, 1'b0, ec, er);
    verify("R4 lanes", 64'h3077, 1'b0, ec, er);
  endtask

  task automatic t_index();      // R5
    int ec, er;
    exec(64'h4000, 12, 8'h00, 5'd6, 5'd0, 5'd7, 1'b0, ec, er);
    verify("R5 index protect", 64'h4000, 1'b0, ec, er);
  endtask

  task automatic t_base();       // R6: base nonzero, then base 0
    int ec, er;
    exec(64'h5000, 9, 8'h00, 5'd1, 5'd2, 5'd31, 1'b0, ec, er);
    verify("R6 base protect", 64'h5000, 1'b0, ec, er);
    exec(64'h5100, 6, 8'h00, 5'd0, 5'd0, 5'd31, 1'b0, ec, er);
    verify("R6 base zero", 64'h5100, 1'b0, ec, er);
  endtask

  task automatic t_match();      // R7: middle and first byte
    int ec, er;
    exec(64'h6020, 20, 8'h35, 5'd12, 5'd0, 5'd0, 1'b0, ec, er);
    verify("R7 match mid", 64'h6020, 1'b0, ec, er);
    chk("R7 match mid count", 64'(got_cnt), 64'd5);
    exec(64'h6020, 20, 8'h30, 5'd12, 5'd0, 5'd0, 1'b0, ec, er);
    verify("R7 match first", 64'h6020, 1'b0, ec, er);
    chk("R7 match first count", 64'(got_cnt), 64'd0);
  endtask

  task automatic t_full();       // R8: maximum count
    int ec, er;
    exec(64'h7000, 127, 8'h00, 5'd0, 5'd0, 5'd31, 1'b0, ec, er);
    verify("R8 full count", 64'h7000, 1'b0, ec, er);
    chk("R8 full count value", 64'(got_cnt), 64'd127);
  endtask

  task automatic t_zero();       // R9
    int ec, er;
    exec(64'h8000, 0, 8'h00, 5'd4, 5'd0, 5'd1, 1'b0, ec, er);
    verify("R9 zero count", 64'h8000, 1'b0, ec, er);
  endtask

  task automatic t_addr();       // R10
    int ec, er;
    exec(64'hFFFF_FFFE, 4, 8'h00, 5'd8, 5'd0, 5'd1, 1'b1, ec, er);
    verify("R10 32-bit wrap", 64'hFFFF_FFFE, 1'b1, ec, er);
    chk("R10 32-bit third addr", alog[2], 64'h0);
    exec(64'hFFFF_FFFE, 4, 8'h00, 5'd8, 5'd0, 5'd1, 1'b0, ec, er);
    verify("R10 64-bit carry", 64'hFFFF_FFFE, 1'b0, ec, er);
    chk("R10 64-bit third addr", alog[2], 64'h1_0000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_match();
    t_reg_wrap();
    t_lanes();
    t_index();
    t_base();
    t_match();
    t_full();
    t_zero();
    t_addr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule